// File: doc/BRIEF.md
# Two-Target Serial-Bus Write Slave

This block is the write-side front end of a two-wire serial slave. One bus reaches two targets: a bank of volatile 16-bit sensor registers and a byte-addressed non-volatile memory. It samples the clock and data lines into the system clock domain and finds START and STOP conditions. It matches the device address of each target, acknowledges the bytes it accepts, and splits a write into an address byte and a run of data bytes. It then turns these into write strobes for the target that was addressed. Read transactions are answered with silence.

Memory bytes go downstream one at a time as they arrive. The byte pointer steps through a 16-byte page and wraps inside that page. The STOP that ends a memory write raises a one-cycle pulse, which tells the memory controller to begin its internal write cycle. While that controller reports busy, the memory device address gets no acknowledge, so a master can poll until the memory is free. Register data is staged, most significant byte first, and is committed to the addressed register only when the closing STOP arrives.

Top module: `i2c_dual_write_slave`

## Requirements
- R1: After reset the data line is released (`sda_oe_o` = 0) and no strobe or pulse output is high.
- R2: A device byte is acknowledged only when its upper 7 bits equal the register address (default 0x18) or the memory address (default 0x50) and its bit 0 (read/write) is 0. Any other byte, and any read request, gets no acknowledge, and the rest of that transaction produces no strobe.
- R3: In a memory transaction the address byte and every data byte are acknowledged. Each data byte gives one `mem_wr_o` pulse that carries the byte and its memory address. A register write and a memory write strobe are never high in the same cycle.
- R4: The memory address starts at the address byte and increases by one after each data byte. Only its low 4 bits count, wrapping from 0xF to 0x0, and its upper bits stay those of the address byte.
- R5: A STOP that ends a memory transaction which carried at least one data byte gives exactly one `mem_stop_o` pulse. A STOP after no data byte gives none.
- R6: While `mem_busy_i` is 1 the memory device address is not acknowledged, but the register device address still is.
- R7: A register write takes two data bytes, the first being bits 15:8. `reg_wr_o` pulses once on the STOP, with `reg_addr_o` equal to the address byte and `reg_data_o` equal to the two bytes. No pulse comes before the STOP.
- R8: A register transaction stopped after only one data byte commits nothing. A third register data byte is not acknowledged and is dropped, and the STOP still commits the first two bytes.
- R9: The acknowledge drive is low-active through `sda_oe_o`. It is off while the eighth bit is on the bus, on through the ninth clock, and off again shortly after SCL falls at the end of that clock. It never changes while SCL stays high.
- R10: A repeated START abandons the transaction in progress. Register bytes staged before it are not committed by a later STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line as seen on the wire, asynchronous |
| mem_busy_i | input | 1 | Memory internal write cycle in progress |
| sda_oe_o | output | 1 | 1 pulls the data line low (open-drain acknowledge) |
| reg_wr_o | output | 1 | One-cycle register commit strobe |
| reg_addr_o | output | 8 | Register index for the commit |
| reg_data_o | output | 16 | Register value for the commit |
| mem_wr_o | output | 1 | One-cycle memory byte strobe |
| mem_addr_o | output | 8 | Memory byte address |
| mem_data_o | output | 8 | Memory byte data |
| mem_stop_o | output | 1 | One-cycle pulse: start the memory write cycle |

## Verification
The bus lines pass through a two-flop synchronizer and one edge register. So a START or STOP, or an SCL edge, reaches the decoder three cycles after the line changes. A byte strobe appears about five cycles after the rising SCL edge of the eighth bit, and a commit or memory-stop pulse about five cycles after SDA rises for STOP. The bench holds every SCL phase for 20 cycles and reads strobe counts and captured values only at the end of a byte or after the STOP phase. At that point every due result has settled and the next one cannot have started. The acknowledge is sampled at the middle of the ninth SCL high phase, and the release is sampled 8 cycles after the following SCL fall.

// File: rtl/i2c_dw_pkg.sv
// Package: shared types for the two-target write slave.
// Assumes: nothing; pure type definitions.
package i2c_dw_pkg;

    // Target selected by the device byte of the current transaction.
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_REG  = 2'd1,
        TGT_MEM  = 2'd2
    } tgt_e;

    // Frame decoder states.
    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_RX   = 2'd1,
        FS_ACK  = 2'd2,
        FS_SKIP = 2'd3
    } fstate_e;

endpackage

// File: rtl/i2c_dw_line_sync.sv
// Module: brings SCL and SDA into the clock domain and derives bus events.
// Assumes: the clock runs well above SCL; STAGES >= 2 synchronizer flops,
// then one extra flop that holds the previous synchronized level.
module i2c_dw_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES:0] scl_pipe;
    logic [STAGES:0] sda_pipe;
    logic            scl_old;
    logic            sda_old;

    // Shift both lines through the synchronizer chain; idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-1:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-1:0], sda_i};
        end
    end

    assign scl_lvl   = scl_pipe[STAGES-1];
    assign sda_lvl   = sda_pipe[STAGES-1];
    assign scl_old   = scl_pipe[STAGES];
    assign sda_old   = sda_pipe[STAGES];
    assign scl_rise  = scl_lvl & ~scl_old;
    assign scl_fall  = ~scl_lvl & scl_old;
    assign start_det = scl_lvl & scl_old & sda_old & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_old & ~sda_old & sda_lvl;

endmodule

// File: rtl/i2c_dw_frame.sv
// Module: byte framing, device address match and acknowledge generation.
// Assumes: events come from i2c_dw_line_sync; byte index 0 is the device
// byte, 1 the address byte, 2 and up the data bytes (saturating).
module i2c_dw_frame
    import i2c_dw_pkg::*;
#(
    parameter logic [6:0] REG_DEV   = 7'h18,
    parameter logic [6:0] MEM_DEV   = 7'h50,
    parameter int         REG_BYTES = 2,
    parameter int         IW        = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_lvl,
    input  logic          sda_lvl,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic          mem_busy,
    output logic          ack_drive_o,
    output logic          byte_stb_o,
    output logic [7:0]    byte_o,
    output logic [IW-1:0] byte_idx_o,
    output tgt_e          tgt_o
);
    localparam int IDX_MAX = 2 + REG_BYTES;

    fstate_e       state;
    logic [6:0]    shreg;
    logic [2:0]    bit_cnt;
    logic [IW-1:0] idx;
    logic [7:0]    full_byte;
    tgt_e          dev_tgt;
    logic          ack_ok;

    assign full_byte = {shreg, sda_lvl};

    // Decide which target a completed device byte selects.
    always_comb begin
        dev_tgt = TGT_NONE;
        if (!full_byte[0]) begin
            if (full_byte[7:1] == REG_DEV)
                dev_tgt = TGT_REG;
            else if (full_byte[7:1] == MEM_DEV && !mem_busy)
                dev_tgt = TGT_MEM;
        end
    end

    // Decide whether the byte completing now earns an acknowledge.
    always_comb begin
        if (idx == '0)
            ack_ok = (dev_tgt != TGT_NONE);
        else if (idx == IW'(1))
            ack_ok = 1'b1;
        else
            ack_ok = (tgt_o == TGT_MEM) || (idx < IW'(IDX_MAX));
    end

    // Frame state machine: shift bits, acknowledge, track byte index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= FS_IDLE;
            shreg       <= '0;
            bit_cnt     <= '0;
            idx         <= '0;
            tgt_o       <= TGT_NONE;
            ack_drive_o <= 1'b0;
            byte_stb_o  <= 1'b0;
            byte_o      <= '0;
        end else begin
            byte_stb_o <= 1'b0;
            if (start_det) begin
                state       <= FS_RX;
                bit_cnt     <= '0;
                idx         <= '0;
                tgt_o       <= TGT_NONE;
                ack_drive_o <= 1'b0;
            end else if (stop_det) begin
                state       <= FS_IDLE;
                ack_drive_o <= 1'b0;
            end else begin
                case (state)
                    FS_RX: begin
                        if (scl_rise) begin
                            if (bit_cnt == 3'd7) begin
                                bit_cnt <= '0;
                                if (ack_ok) begin
                                    state      <= FS_ACK;
                                    byte_o     <= full_byte;
                                    byte_stb_o <= (idx != '0);
                                    if (idx == '0)
                                        tgt_o <= dev_tgt;
                                end else begin
                                    state <= FS_SKIP;
                                end
                            end else begin
                                shreg   <= full_byte[6:0];
                                bit_cnt <= bit_cnt + 3'd1;
                            end
                        end
                    end
                    FS_ACK: begin
                        if (scl_fall) begin
                            if (!ack_drive_o) begin
                                ack_drive_o <= 1'b1;
                            end else begin
                                ack_drive_o <= 1'b0;
                                state       <= FS_RX;
                                if (idx != IW'(IDX_MAX))
                                    idx <= idx + IW'(1);
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign byte_idx_o = idx;

    // The acknowledge is only given inside an addressed transaction.
    assert_ack_needs_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_drive_o |-> tgt_o != TGT_NONE);

    // The acknowledge drive never moves while SCL is held high.
    assert_ack_stable_scl_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl) && !start_det && !stop_det) |-> $stable(ack_drive_o));

    // A STOP releases the data line on the next cycle.
    assert_stop_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !ack_drive_o);

endmodule

// File: rtl/i2c_dual_write_slave.sv
// Module: top of the two-target write slave. Routes accepted bytes either
// to the memory strobe port (paged address counter) or into the register
// staging buffer, committed on STOP.
// Assumes: the memory controller raises mem_busy_i for its whole write cycle.
module i2c_dual_write_slave
    import i2c_dw_pkg::*;
#(
    parameter logic [6:0] REG_DEV   = 7'h18,
    parameter logic [6:0] MEM_DEV   = 7'h50,
    parameter int         ADDR_W    = 8,
    parameter int         PAGE_BITS = 4,
    parameter int         REG_BYTES = 2,
    parameter int         SYNC_W    = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    input  logic                   mem_busy_i,
    output logic                   sda_oe_o,
    output logic                   reg_wr_o,
    output logic [ADDR_W-1:0]      reg_addr_o,
    output logic [8*REG_BYTES-1:0] reg_data_o,
    output logic                   mem_wr_o,
    output logic [ADDR_W-1:0]      mem_addr_o,
    output logic [7:0]             mem_data_o,
    output logic                   mem_stop_o
);
    localparam int IW     = $clog2(2 + REG_BYTES + 1);
    localparam int RDW    = 8 * REG_BYTES;
    localparam int SCW    = $clog2(REG_BYTES + 1);
    localparam int PAGE_W = ADDR_W - PAGE_BITS;

    logic          scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic          byte_stb;
    logic [7:0]    byte_val;
    logic [IW-1:0] byte_idx;
    tgt_e          tgt;

    logic [ADDR_W-1:0] mem_ptr;
    logic [PAGE_W-1:0] page_q;
    logic [ADDR_W-1:0] reg_addr_q;
    logic [7:0]        stage [REG_BYTES];
    logic [RDW-1:0]    stage_packed;
    logic [SCW-1:0]    stage_cnt;
    logic              mem_any;

    i2c_dw_line_sync #(.STAGES(SYNC_W)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_dw_frame #(
        .REG_DEV   (REG_DEV),
        .MEM_DEV   (MEM_DEV),
        .REG_BYTES (REG_BYTES),
        .IW        (IW)
    ) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_lvl     (scl_lvl),
        .sda_lvl     (sda_lvl),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .mem_busy    (mem_busy_i),
        .ack_drive_o (sda_oe_o),
        .byte_stb_o  (byte_stb),
        .byte_o      (byte_val),
        .byte_idx_o  (byte_idx),
        .tgt_o       (tgt)
    );

    // Pack the staging bytes, first received byte most significant.
    for (genvar g = 0; g < REG_BYTES; g++) begin : g_pack
        assign stage_packed[RDW-1-8*g -: 8] = stage[g];
    end

    // Route accepted bytes and issue the strobes and pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ptr    <= '0;
            page_q     <= '0;
            reg_addr_q <= '0;
            stage_cnt  <= '0;
            mem_any    <= 1'b0;
            reg_wr_o   <= 1'b0;
            reg_addr_o <= '0;
            reg_data_o <= '0;
            mem_wr_o   <= 1'b0;
            mem_addr_o <= '0;
            mem_data_o <= '0;
            mem_stop_o <= 1'b0;
            for (int i = 0; i < REG_BYTES; i++) stage[i] <= '0;
        end else begin
            reg_wr_o   <= 1'b0;
            mem_wr_o   <= 1'b0;
            mem_stop_o <= 1'b0;
            if (start_det) begin
                stage_cnt <= '0;
                mem_any   <= 1'b0;
            end else if (stop_det) begin
                if (tgt == TGT_REG && stage_cnt == SCW'(REG_BYTES)) begin
                    reg_wr_o   <= 1'b1;
                    reg_addr_o <= reg_addr_q;
                    reg_data_o <= stage_packed;
                end
                if (tgt == TGT_MEM && mem_any)
                    mem_stop_o <= 1'b1;
                stage_cnt <= '0;
                mem_any   <= 1'b0;
            end else if (byte_stb) begin
                if (byte_idx == IW'(1)) begin
                    mem_ptr    <= ADDR_W'(byte_val);
                    page_q     <= byte_val[ADDR_W-1:PAGE_BITS];
                    reg_addr_q <= ADDR_W'(byte_val);
                end else if (tgt == TGT_MEM) begin
                    mem_wr_o   <= 1'b1;
                    mem_addr_o <= mem_ptr;
                    mem_data_o <= byte_val;
                    mem_ptr    <= {mem_ptr[ADDR_W-1:PAGE_BITS],
                                   mem_ptr[PAGE_BITS-1:0] + PAGE_BITS'(1)};
                    mem_any    <= 1'b1;
                end else if (tgt == TGT_REG && stage_cnt < SCW'(REG_BYTES)) begin
                    stage[stage_cnt] <= byte_val;
                    stage_cnt        <= stage_cnt + SCW'(1);
                end
            end
        end
    end

    // A register commit only follows a STOP.
    assert_regwr_on_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |-> $past(stop_det));

    // The memory cycle start only follows a STOP.
    assert_memstop_on_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_stop_o |-> $past(stop_det));

    // Memory bytes stay in the page named by the address byte.
    assert_page_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> mem_addr_o[ADDR_W-1:PAGE_BITS] == page_q);

    // The two targets never strobe together.
    assert_one_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr_o && reg_wr_o));

endmodule

// File: tb/i2c_dual_write_slave_tb.sv
module i2c_dual_write_slave_tb;
    localparam int H = 20;
    localparam logic [6:0] REG_DEV = 7'h18;
    localparam logic [6:0] MEM_DEV = 7'h50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic mem_busy = 1'b0;
    logic sda_oe, reg_wr, mem_wr, mem_stop;
    logic [7:0] reg_addr, mem_addr, mem_data;
    logic [15:0] reg_data;
    logic sda_line;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int mw_cnt = 0, rw_cnt = 0, ms_cnt = 0;
    logic [7:0] mw_addr [64];
    logic [7:0] mw_data [64];
    logic [7:0] rw_addr_last;
    logic [15:0] rw_data_last;

    logic oe_bit8, oe_slot, oe_after;
    logic [7:0] dbuf [16];

    assign sda_line = m_sda & ~sda_oe;

    always #5 clk = ~clk;

    i2c_dual_write_slave u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_line),
        .mem_busy_i (mem_busy),
        .sda_oe_o   (sda_oe),
        .reg_wr_o   (reg_wr),
        .reg_addr_o (reg_addr),
        .reg_data_o (reg_data),
        .mem_wr_o   (mem_wr),
        .mem_addr_o (mem_addr),
        .mem_data_o (mem_data),
        .mem_stop_o (mem_stop)
    );

    // Capture every strobe the design emits.
    always @(posedge clk) begin
        if (mem_wr) begin
            mw_addr[mw_cnt % 64] <= mem_addr;
            mw_data[mw_cnt % 64] <= mem_data;
            mw_cnt <= mw_cnt + 1;
        end
        if (reg_wr) begin
            rw_addr_last <= reg_addr;
            rw_data_last <= reg_data;
            rw_cnt <= rw_cnt + 1;
        end
        if (mem_stop) ms_cnt <= ms_cnt + 1;
    end

    function automatic logic [7:0] exp_mem_addr(logic [7:0] base, int i);
        return {base[7:4], 4'(base[3:0] + i)};
    endfunction

    function automatic logic exp_dev_ack(logic [7:0] b, logic busy);
        if (b[0]) return 1'b0;
        if (b[7:1] == REG_DEV) return 1'b1;
        if (b[7:1] == MEM_DEV) return !busy;
        return 1'b0;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(H);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b0; tick(H);
        m_scl = 1'b0; tick(H);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(H);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b1; tick(H);
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(H);
            m_scl = 1'b1; tick(H);
            if (i == 0) oe_bit8 = sda_oe;
            m_scl = 1'b0;
        end
        m_sda = 1'b1; tick(H);
        m_scl = 1'b1; tick(H / 2);
        ack = !sda_line;
        oe_slot = sda_oe;
        tick(H / 2);
        m_scl = 1'b0; tick(8);
        oe_after = sda_oe;
    endtask

    // Memory write of n bytes from dbuf at base; checks acks, strobes, pulse.
    task automatic mem_txn(logic [7:0] base, int n);
        logic ack;
        int s, ms0;
        s = mw_cnt; ms0 = ms_cnt;
        bus_start();
        write_byte({MEM_DEV, 1'b0}, ack); check("R2 mem dev ack", ack, 1);
        write_byte(base, ack);            check("R3 mem addr ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            write_byte(dbuf[i], ack);     check("R3 mem data ack", ack, 1);
        end
        bus_stop();
        check("R3 mem strobe count", mw_cnt - s, n);
        for (int i = 0; i < n; i++) begin
            check("R4 mem address", mw_addr[(s + i) % 64], exp_mem_addr(base, i));
            check("R3 mem data", mw_data[(s + i) % 64], dbuf[i]);
        end
        check("R5 mem stop pulse", ms_cnt - ms0, (n > 0) ? 1 : 0);
    endtask

    // Register write of n bytes from dbuf; checks acks and the commit.
    task automatic reg_txn(logic [7:0] ra, int n);
        logic ack;
        int r0;
        r0 = rw_cnt;
        bus_start();
        write_byte({REG_DEV, 1'b0}, ack); check("R2 reg dev ack", ack, 1);
        write_byte(ra, ack);              check("R7 reg addr ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            write_byte(dbuf[i], ack);
            check("R8 reg data ack", ack, (i < 2) ? 1 : 0);
            if (i >= 2) break;
        end
        check("R7 no commit before stop", rw_cnt - r0, 0);
        bus_stop();
        check("R8 reg commit count", rw_cnt - r0, (n >= 2) ? 1 : 0);
        if (n >= 2) begin
            check("R7 reg addr", rw_addr_last, ra);
            check("R7 reg data", rw_data_last, {dbuf[0], dbuf[1]});
        end
    endtask

    initial begin
        logic ack;
        int s, r0, m0;
        void'($urandom(32'h5EED));
        tick(4);
        rst_n = 1'b1;
        tick(2);
        check("R1 reset sda_oe", sda_oe, 0);
        check("R1 reset strobes", {reg_wr, mem_wr, mem_stop}, 0);

        // Memory write inside a page.
        dbuf[0] = 8'h11; dbuf[1] = 8'h22; dbuf[2] = 8'h33;
        mem_txn(8'h10, 3);

        // Page wrap from 0x3E.
        dbuf[0] = 8'hA0; dbuf[1] = 8'hA1; dbuf[2] = 8'hA2; dbuf[3] = 8'hA3;
        mem_txn(8'h3E, 4);

        // R9: acknowledge timing on a device byte.
        bus_start();
        write_byte({REG_DEV, 1'b0}, ack);
        check("R9 released during bit 8", oe_bit8, 0);
        check("R9 driven in ack slot", oe_slot, 1);
        check("R9 released after ack", oe_after, 0);
        bus_stop();

        // R2: unknown address, then a read request.
        s = mw_cnt; r0 = rw_cnt; m0 = ms_cnt;
        bus_start();
        write_byte({7'h33, 1'b0}, ack); check("R2 foreign address nack", ack, exp_dev_ack({7'h33, 1'b0}, 0));
        write_byte(8'h01, ack);         check("R2 ignored byte nack", ack, 0);
        bus_stop();
        bus_start();
        write_byte({REG_DEV, 1'b1}, ack); check("R2 read request nack", ack, 0);
        write_byte(8'h02, ack);
        bus_stop();
        check("R2 no strobes when ignored", (mw_cnt - s) + (rw_cnt - r0) + (ms_cnt - m0), 0);

        // R7 register write, R8 short and long writes.
        dbuf[0] = 8'hA5; dbuf[1] = 8'h3C;
        reg_txn(8'h05, 2);
        dbuf[0] = 8'h77;
        reg_txn(8'h06, 1);
        dbuf[0] = 8'hBE; dbuf[1] = 8'hEF; dbuf[2] = 8'h99;
        reg_txn(8'h07, 3);

        // R6: busy memory stays silent, registers still answer.
        mem_busy = 1'b1;
        bus_start();
        write_byte({MEM_DEV, 1'b0}, ack); check("R6 busy memory nack", ack, 0);
        bus_stop();
        bus_start();
        write_byte({REG_DEV, 1'b0}, ack); check("R6 register ack while busy", ack, 1);
        bus_stop();
        mem_busy = 1'b0;
        bus_start();
        write_byte({MEM_DEV, 1'b0}, ack); check("R6 memory ack when free", ack, 1);
        bus_stop();

        // R5: memory address byte but no data.
        mem_txn(8'h40, 0);

        // R10: repeated START abandons staged register bytes.
        r0 = rw_cnt;
        bus_start();
        write_byte({REG_DEV, 1'b0}, ack);
        write_byte(8'h09, ack);
        write_byte(8'h12, ack);
        write_byte(8'h34, ack);
        bus_start();
        bus_stop();
        check("R10 no commit after restart", rw_cnt - r0, 0);

        // Random mix of register and memory writes.
        for (int t = 0; t < 12; t++) begin
            int n;
            logic [7:0] a;
            a = 8'($urandom);
            if ($urandom % 2) begin
                n = $urandom % 4;
                for (int i = 0; i < n; i++) dbuf[i] = 8'($urandom);
                reg_txn(a, n);
            end else begin
                n = 1 + $urandom % 6;
                for (int i = 0; i < n; i++) dbuf[i] = 8'($urandom);
                mem_txn(a, n);
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all actual=timeout expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule